// File: doc/BRIEF.md
# Background-Programmable March Test Sequencer

This block is a built-in self-test engine for a single-port, one-bit-wide synchronous SRAM. It runs a 14-operation-per-cell March test with a fixed element structure and fixed address orders. The value of every write, and of every expected read, comes from one bit of a six-bit background word captured at start. Loading a different background turns the same hardware into a different derived March algorithm. One example trades transitional writes for non-transitional ones to reach write-disturb and deceptive-read faults.

A start pulse latches the background and launches the sweep. The engine issues at most one memory operation per cycle. It checks every read word one cycle later against the value it expects. It keeps the element, operation slot and address of the first miscompare, and raises done when the last read has been judged. Pass is done with fail low.

Top module: `bgmarch_engine`

## Requirements
- R1: After reset, busy, done and fail are low and neither mem_we nor mem_re is asserted.
- R2: The background is captured on the cycle start is accepted. Changes on the bg input during a test have no effect on any write value or expected read value.
- R3: There are six elements, numbered 0 to 5 and run in that order. Each cell gets, by slot index from 0: element 0 = W5; element 1 = R5 W4 R4 W3; element 2 = R3 R3; element 3 = W2; element 4 = R2 W1 R1 W0; element 5 = R0 R0. Here Wk writes bg bit k and Rk reads, expecting bg bit k. A test issues exactly 14 x 2^AW operations.
- R4: Every write drives mem_wdata with the latched background bit that its slot selects.
- R5: Element 4 walks the addresses from 2^AW-1 down to 0. All other elements walk from 0 up to 2^AW-1. All slots of one element are done on a cell before the engine moves to the next cell.
- R6: Read data is compared one cycle after the read is issued. A difference from the expected bit sets fail.
- R7: fail is sticky until the next accepted start. fail_elem, fail_op and fail_addr hold the element, slot index and address of the first miscompare and do not change afterwards.
- R8: done rises with busy falling once every read has been compared, and it stays high until the next start. An accepted start clears done and fail.
- R9: A start pulse while busy is ignored: the running sweep continues unchanged.
- R10: No memory operation is issued while busy is low. mem_we and mem_re are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, accepted when idle |
| bg | input | 6 | Background word selecting every data value |
| mem_addr | output | AW | SRAM address |
| mem_we | output | 1 | SRAM write enable |
| mem_re | output | 1 | SRAM read enable |
| mem_wdata | output | 1 | SRAM write data |
| mem_rdata | input | 1 | SRAM read data, valid one cycle after mem_re |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, held until next start |
| fail | output | 1 | Sticky miscompare flag |
| fail_elem | output | 3 | Element of first miscompare |
| fail_op | output | 2 | Slot index within the element of first miscompare |
| fail_addr | output | AW | Address of first miscompare |

## Verification
A wrong element counter, slot index or walker direction shows up within the next issued operation as a wrong enable, address or write bit on the SRAM port. The bench follows the port trace operation by operation, so such a fault is caught within a cycle. A misaligned compare pipeline or a wrong background latch does not show on the write port. It shows as a fail with a wrong or missing location when a stuck cell is modelled, and it becomes visible only when done rises. Stuck-cell placements are chosen so that the first miscompare falls in different elements and slots, including the last double read.

// File: rtl/bgmarch_pkg.sv
package bgmarch_pkg;
  localparam int NUM_ELEM = 6;
  localparam int ELEM_W   = 3;
  localparam int IDX_W    = 2;
  localparam int BG_W     = 6;

  typedef struct packed {
    logic       wr;
    logic [2:0] bsel;
    logic       last;
  } mop_t;

  function automatic mop_t mk_op(input logic wr, input logic [2:0] b, input logic last);
    mop_t m;
    m.wr = wr; m.bsel = b; m.last = last;
    return m;
  endfunction

  // slot table: element e, slot i -> operation kind, background bit, last-slot marker
  function automatic mop_t mop_decode(input logic [ELEM_W-1:0] e, input logic [IDX_W-1:0] i);
    case (e)
      3'd0: return mk_op(1'b1, 3'd5, 1'b1);
      3'd1: case (i)
              2'd0: return mk_op(1'b0, 3'd5, 1'b0);
              2'd1: return mk_op(1'b1, 3'd4, 1'b0);
              2'd2: return mk_op(1'b0, 3'd4, 1'b0);
              default: return mk_op(1'b1, 3'd3, 1'b1);
            endcase
      3'd2: return mk_op(1'b0, 3'd3, i == 2'd1);
      3'd3: return mk_op(1'b1, 3'd2, 1'b1);
      3'd4: case (i)
              2'd0: return mk_op(1'b0, 3'd2, 1'b0);
              2'd1: return mk_op(1'b1, 3'd1, 1'b0);
              2'd2: return mk_op(1'b0, 3'd1, 1'b0);
              default: return mk_op(1'b1, 3'd0, 1'b1);
            endcase
      default: return mk_op(1'b0, 3'd0, i == 2'd1);
    endcase
  endfunction

  function automatic logic elem_down(input logic [ELEM_W-1:0] e);
    return e == 3'd4;
  endfunction

  function automatic logic bg_pick(input logic [BG_W-1:0] bg, input logic [2:0] b);
    logic r;
    r = 1'b0;
    for (int k = 0; k < BG_W; k++)
      if (b == 3'(k)) r = bg[k];
    return r;
  endfunction
endpackage

// File: rtl/bgm_addr_walk.sv
module bgm_addr_walk #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_down,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic down_q;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input logic dn);
    return dn ? a - AW'(1) : a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] first_addr(input logic dn);
    return dn ? TOP : '0;
  endfunction

  assign at_end = down_q ? (addr == '0) : (addr == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      addr   <= first_addr(load_down);
      down_q <= load_down;
    end else if (step) begin
      addr <= next_addr(addr, down_q);
    end
  end

  // R5: the sequencer never asks to step beyond the end of a sweep
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n) step |-> !at_end);
  // R5: a fresh sweep always starts on a boundary cell
  a_r5_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == '0 || addr == TOP));
endmodule

// File: rtl/bgm_seq.sv
module bgm_seq
  import bgmarch_pkg::*;
#(
  parameter int AW     = 6,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BG_W-1:0]   bg,
  output logic              launch,
  output logic              busy,
  output logic              done,
  output logic              iss_valid,
  output logic              iss_wr,
  output logic              iss_data,
  output logic [ELEM_W-1:0] iss_elem,
  output logic [IDX_W-1:0]  iss_idx,
  output logic [AW-1:0]     iss_addr
);
  localparam int CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEM - 1);
  localparam logic [CW-1:0]     DRAIN_END = CW'(RD_LAT - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_t;

  st_t               st;
  logic [ELEM_W-1:0] elem;
  logic [IDX_W-1:0]  idx;
  logic [BG_W-1:0]   bg_q;
  logic [CW-1:0]     dcnt;
  logic              done_q;
  mop_t              op;
  logic              at_end, step, elem_adv, finish, wl_load, wl_down;

  assign op        = mop_decode(elem, idx);
  assign launch    = (st == S_IDLE) && start;
  assign iss_valid = (st == S_RUN);
  assign step      = iss_valid && op.last && !at_end;
  assign elem_adv  = iss_valid && op.last && at_end && (elem != LAST_ELEM);
  assign finish    = iss_valid && op.last && at_end && (elem == LAST_ELEM);
  assign wl_load   = launch || elem_adv;
  assign wl_down   = launch ? elem_down('0) : elem_down(elem + ELEM_W'(1));

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign iss_wr   = op.wr;
  assign iss_data = bg_pick(bg_q, op.bsel);
  assign iss_elem = elem;
  assign iss_idx  = idx;

  bgm_addr_walk #(.AW(AW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wl_load),
    .load_down (wl_down),
    .step      (step),
    .addr      (iss_addr),
    .at_end    (at_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      elem   <= '0;
      idx    <= '0;
      bg_q   <= '0;
      dcnt   <= '0;
      done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          bg_q   <= bg;
          elem   <= '0;
          idx    <= '0;
          done_q <= 1'b0;
          st     <= S_RUN;
        end
        S_RUN: begin
          if (!op.last) begin
            idx <= idx + IDX_W'(1);
          end else begin
            idx <= '0;
            if (finish) begin
              st   <= S_DRAIN;
              dcnt <= '0;
            end else if (elem_adv) begin
              elem <= elem + ELEM_W'(1);
            end
          end
        end
        S_DRAIN: begin
          if (dcnt == DRAIN_END) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            dcnt <= dcnt + CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: a cell keeps its address until its last slot of the element has run
  a_r5_cell_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !op.last) |=> ($stable(iss_addr) && iss_valid));
  // R2: the captured background does not move while a test is running
  a_r2_bg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !launch) |=> $stable(bg_q));
  // R9: a start seen while busy does not restart the sweep
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && elem != '0) |=> (elem != '0 || !busy));
endmodule

// File: rtl/bgm_rd_check.sv
module bgm_rd_check
  import bgmarch_pkg::*;
#(
  parameter int AW     = 6,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              iss_valid,
  input  logic              iss_wr,
  input  logic              iss_data,
  input  logic [ELEM_W-1:0] iss_elem,
  input  logic [IDX_W-1:0]  iss_idx,
  input  logic [AW-1:0]     iss_addr,
  input  logic              rdata,
  output logic              fail,
  output logic [ELEM_W-1:0] fail_elem,
  output logic [IDX_W-1:0]  fail_idx,
  output logic [AW-1:0]     fail_addr
);
  typedef struct packed {
    logic              v;
    logic              exp;
    logic [ELEM_W-1:0] e;
    logic [IDX_W-1:0]  i;
    logic [AW-1:0]     a;
  } rtag_t;

  rtag_t pipe [RD_LAT];
  rtag_t cur, tail;
  logic  cmp_valid, mismatch;

  always_comb begin
    cur.v   = iss_valid && !iss_wr;
    cur.exp = iss_data;
    cur.e   = iss_elem;
    cur.i   = iss_idx;
    cur.a   = iss_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= cur;
  end

  genvar g;
  generate
    for (g = 1; g < RD_LAT; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign tail      = pipe[RD_LAT-1];
  assign cmp_valid = tail.v;
  assign mismatch  = cmp_valid && (rdata != tail.exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_elem <= '0;
      fail_idx  <= '0;
      fail_addr <= '0;
    end else if (clear) begin
      fail      <= 1'b0;
      fail_elem <= '0;
      fail_idx  <= '0;
      fail_addr <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_elem <= tail.e;
      fail_idx  <= tail.i;
      fail_addr <= tail.a;
    end
  end

  // R6: a miscompare is flagged on the following edge
  a_r6_flag_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !clear) |=> fail);
  // R7: the flag stays up until a new test is launched
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> fail);
  // R7: the recorded location belongs to the first miscompare only
  a_r7_loc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> ($stable(fail_elem) && $stable(fail_idx) && $stable(fail_addr)));
endmodule

// File: rtl/bgmarch_engine.sv
module bgmarch_engine
  import bgmarch_pkg::*;
#(
  parameter int AW     = 6,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    bg,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic          mem_wdata,
  input  logic          mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [2:0]    fail_elem,
  output logic [1:0]    fail_op,
  output logic [AW-1:0] fail_addr
);
  logic              launch, iss_valid, iss_wr, iss_data;
  logic [ELEM_W-1:0] iss_elem;
  logic [IDX_W-1:0]  iss_idx;
  logic [AW-1:0]     iss_addr;

  bgm_seq #(.AW(AW), .RD_LAT(RD_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bg        (bg),
    .launch    (launch),
    .busy      (busy),
    .done      (done),
    .iss_valid (iss_valid),
    .iss_wr    (iss_wr),
    .iss_data  (iss_data),
    .iss_elem  (iss_elem),
    .iss_idx   (iss_idx),
    .iss_addr  (iss_addr)
  );

  bgm_rd_check #(.AW(AW), .RD_LAT(RD_LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .iss_valid (iss_valid),
    .iss_wr    (iss_wr),
    .iss_data  (iss_data),
    .iss_elem  (iss_elem),
    .iss_idx   (iss_idx),
    .iss_addr  (iss_addr),
    .rdata     (mem_rdata),
    .fail      (fail),
    .fail_elem (fail_elem),
    .fail_idx  (fail_op),
    .fail_addr (fail_addr)
  );

  assign mem_addr  = iss_addr;
  assign mem_we    = iss_valid && iss_wr;
  assign mem_re    = iss_valid && !iss_wr;
  assign mem_wdata = mem_we && iss_data;

  // R10: memory stays quiet outside a test
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re));
  // R10: one operation per cycle at most
  a_r10_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R8: completion and activity are exclusive
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8: done only rises as busy falls
  a_r8_done_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));
endmodule

// File: tb/bgmarch_engine_bench.sv
module bgmarch_engine_bench;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [5:0]    bg_in = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re, mem_wdata, mem_rdata;
  logic          busy, done, fail;
  logic [2:0]    fail_elem;
  logic [1:0]    fail_op;
  logic [AW-1:0] fail_addr;

  always #5 clk = ~clk;

  bgmarch_engine #(.AW(AW), .RD_LAT(1)) u_bgmarch_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .bg(bg_in),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail),
    .fail_elem(fail_elem), .fail_op(fail_op), .fail_addr(fail_addr)
  );

  // SRAM model with an optional stuck cell
  logic mem [N];
  logic rd_q = 1'b0;
  logic f_en = 1'b0;
  int   f_addr = 0;
  logic f_val = 1'b0;
  assign mem_rdata = rd_q;

  always @(posedge clk) begin
    if (mem_we && !(f_en && int'(mem_addr) == f_addr)) mem[mem_addr] <= mem_wdata;
    if (mem_re) rd_q <= (f_en && int'(mem_addr) == f_addr) ? f_val : mem[mem_addr];
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent restatement of the slot table: code = 8*write + bit
  function automatic int b_len(input int e);
    return (e == 1 || e == 4) ? 4 : ((e == 2 || e == 5) ? 2 : 1);
  endfunction

  function automatic int b_code(input int e, input int i);
    int wlist[6] = '{0, 8, 0, 8, 0, 8};
    case (e)
      0: return 13;
      1: return wlist[i] + 5 - (i + 1) / 2;
      2: return 3;
      3: return 10;
      4: return wlist[i] + 2 - (i + 1) / 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit b_down(input int e);
    return e == 4;
  endfunction

  function automatic int b_first(input int e);
    return b_down(e) ? N - 1 : 0;
  endfunction

  function automatic int b_last(input int e);
    return b_down(e) ? 0 : N - 1;
  endfunction

  // expected first miscompare for a stuck cell
  task automatic exp_fail(input logic [5:0] bg, input bit en, input int sa, input bit sv,
                          output bit found, output int fe, output int fi, output int fa);
    found = 0; fe = 0; fi = 0; fa = 0;
    for (int e = 0; e < 6; e++)
      for (int s = 0; s < N; s++) begin
        int a;
        a = b_down(e) ? N - 1 - s : s;
        for (int i = 0; i < b_len(e); i++) begin
          int c;
          c = b_code(e, i);
          if (en && !found && c < 8 && a == sa && bg[c] != sv) begin
            found = 1; fe = e; fi = i; fa = a;
          end
        end
      end
  endtask

  // port trace follower
  bit          mon_on = 0;
  logic [5:0]  bg_ref = '0;
  int          r_e = 0, r_i = 0, r_a = 0, ops = 0, tr_err = 0;
  string       tr_tag = "";
  longint      tr_act = 0, tr_exp = 0;

  task automatic note(input string tag, input longint act, input longint exp);
    if (tr_err == 0) begin tr_tag = tag; tr_act = act; tr_exp = exp; end
    tr_err++;
  endtask

  always @(negedge clk) if (mon_on) begin
    if ((mem_we || mem_re) && !busy) note("R10 op while idle", 1, 0);
    if (mem_we && mem_re) note("R10 two ops", 2, 1);
    if (mem_we || mem_re) begin
      if (r_e > 5) note("R3 extra op", ops, 14 * N);
      else begin
        int c;
        bit w;
        c = b_code(r_e, r_i);
        w = c >= 8;
        if (mem_we != w) note("R3 op kind", longint'(mem_we), longint'(w));
        if (int'(mem_addr) != r_a) note("R5 address", longint'(mem_addr), r_a);
        if (w && mem_wdata != bg_ref[c % 8]) note("R4 write data", longint'(mem_wdata), longint'(bg_ref[c % 8]));
        if (r_i + 1 < b_len(r_e)) r_i++;
        else begin
          r_i = 0;
          if (r_a == b_last(r_e)) begin r_e++; r_a = (r_e < 6) ? b_first(r_e) : 0; end
          else r_a = b_down(r_e) ? r_a - 1 : r_a + 1;
        end
      end
      ops++;
    end
  end

  task automatic run_test(input logic [5:0] bg, input bit en, input int sa, input bit sv, input bit disturb);
    bit found; int fe, fi, fa;
    f_en = en; f_addr = sa; f_val = sv;
    bg_ref = bg; r_e = 0; r_i = 0; r_a = 0; ops = 0; tr_err = 0;
    exp_fail(bg, en, sa, sv, found, fe, fi, fa);
    @(negedge clk);
    start = 1'b1; bg_in = bg;
    @(negedge clk);
    start = 1'b0;
    if (disturb) bg_in = ~bg;  // R2: live input moves after capture
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    chk(done == 1'b0 && fail == 1'b0, "R8 start clears done/fail", {done, fail}, 0);
    if (disturb) begin
      repeat (N + 3) @(negedge clk);
      start = 1'b1;  // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
      bg_in = $urandom;
    end
    for (int c = 0; c < 20 * N && !done; c++) @(negedge clk);
    chk(done && !busy, "R8 done held, busy low", {done, busy}, 2);
    chk(tr_err == 0, $sformatf("trace %s", tr_tag), tr_act, tr_exp);
    chk(ops == 14 * N, "R3 op count", ops, 14 * N);
    chk(fail == found, "R6 fail flag", fail, found);
    if (found) begin
      chk(int'(fail_elem) == fe, "R7 fail element", fail_elem, fe);
      chk(int'(fail_op) == fi, "R7 fail slot", fail_op, fi);
      chk(int'(fail_addr) == fa, "R7 fail address", fail_addr, fa);
    end
    repeat (4) @(negedge clk);
    chk(fail == found && done, "R7 flag sticky after end", fail, found);
    chk(tr_err == 0 && ops == 14 * N, "R10 quiet after end", ops, 14 * N);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < N; k++) mem[k] = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail, "R1 reset flags", {busy, done, fail}, 0);
    chk(!mem_we && !mem_re, "R1 reset quiet", {mem_we, mem_re}, 0);
    rst_n = 1'b1;
    mon_on = 1;
    @(negedge clk);
    chk(!busy && !mem_we && !mem_re, "R1 idle after reset", busy, 0);

    run_test(6'b000000, 0, 0, 0, 0);
    run_test(6'b111111, 1, 0, 0, 0);
    run_test(6'b001100, 1, N - 1, 1, 0);
    run_test(6'b100000, 1, 3, 1, 0);
    run_test(6'b111110, 1, N - 1, 1, 0);   // first miss in the last double read
    run_test(6'b010011, 1, 7, 0, 1);
    run_test(6'b001011, 0, 0, 0, 1);
    for (int k = 0; k < 12; k++) begin
      logic [5:0] b;
      b = 6'($urandom);
      run_test(b, bit'($urandom % 3 != 0), int'($urandom % N), bit'($urandom), bit'(k % 2));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule